// File: doc/BRIEF.md
# Strap-Initialized Chip Configuration Register

This block is one 32-bit configuration word that sits on a simple register bus. It holds a few pieces of system setup that the rest of the chip reads as levels. The bus-clock rate select and the watchdog routing control are writable. The boot-source code, the host/target mode and the core timer-interrupt disable are read-only. Their values are latched from board strap levels while reset is held. A sticky flag records that a write on the bus ended in an error, and software clears it by writing a one to it.

The block also steers a watchdog timeout event. Depending on the routing bit, the event becomes a one-cycle non-maskable interrupt request or a one-cycle chip reset request. Bus access is single-cycle: a write takes effect at the next clock edge, and read data is registered, so it appears one cycle after the read request. Only one configured word offset responds. The boot code is 011 for PCI boot and 101, 110 or 111 for external bus channel 0 at third, half or full speed. The remaining codes are reserved and are only reported.

Top module: `cfg_strap_reg`

## Requirements
- R1: The rate field sits at bits 25:24, is read/write, resets to 00 and drives `clkRateSel` from the clock edge of the write. The codes are 00 full, 01 half, 10 quarter and 11 eighth bus speed.
- R2: Bits 23:21 read the `strapBoot` level present at the last clock edge with reset asserted. Writes do not change them.
- R3: Bit 20 reads the captured `strapHost` level (1 = host, 0 = target) and is read-only.
- R4: Bit 17 and the `timerIntDis` output both equal the captured `strapTmrDis` level (1 = core timer interrupt disabled). Bit 17 is read-only.
- R5: After reset is released, strap input changes have no effect on any field or output until the next reset.
- R6: Bit 16 is a sticky error flag. It resets to 0 and is set by a cycle with `wrBusErr` high. Writing 1 to bit 16 clears it, and writing 0 leaves it unchanged.
- R7: When `wrBusErr` and a write of 1 to bit 16 happen in the same cycle, the flag ends up set.
- R8: Bit 15 is the routing bit and resets to 0. A `wdtEvent` cycle gives a one-cycle `nmiReq` pulse on the next cycle when the bit is 0, or a one-cycle `rstReq` pulse when it is 1. The two requests are never high together.
- R9: Bits 31:26, 19:18 and 14:0 always read 0, and writes to them are ignored.
- R10: Only `busAddr == CFG_OFFSET` responds. Writes elsewhere change nothing. Read data appears on `busRdData` in the cycle after a matching read request and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; straps are latched while low |
| strapBoot | input | 3 | Boot-source strap level |
| strapHost | input | 1 | Host/target mode strap level |
| strapTmrDis | input | 1 | Timer-interrupt disable strap level |
| busAddr | input | ADDR_W | Register word address |
| busWrEn | input | 1 | Write request this cycle |
| busRdEn | input | 1 | Read request this cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Registered read data |
| wrBusErr | input | 1 | Write bus error event |
| wdtEvent | input | 1 | Watchdog timeout event |
| clkRateSel | output | 2 | Bus clock rate select |
| nmiReq | output | 1 | Non-maskable interrupt request pulse |
| rstReq | output | 1 | Chip reset request pulse |
| timerIntDis | output | 1 | Core timer-interrupt disable level |

## Verification
The bench drives an error event and a one-to-clear write in the same cycle. A design that let the clear win would lose the error record. It moves the straps after reset is released, to catch a design that follows the pins live instead of holding the latched value. It also writes all-ones to the word, to catch read-only or reserved bits that take write data, and writes and reads at other offsets, to catch an address decoder that ignores the offset. Watchdog events arrive under both routing settings, and some arrive in the same cycle as a routing write. A wrong design there would raise the wrong request or use the new routing one cycle too early.

// File: rtl/cfg_strap_pkg.sv
package cfg_strap_pkg;
  localparam int DATA_W    = 32;
  localparam int RATE_LO   = 24;
  localparam int RATE_W    = 2;
  localparam int BOOT_LO   = 21;
  localparam int BOOT_W    = 3;
  localparam int HOST_BIT  = 20;
  localparam int TDIS_BIT  = 17;
  localparam int BERR_BIT  = 16;
  localparam int ROUTE_BIT = 15;

  typedef struct packed {
    logic wrHit;
    logic rdHit;
    logic errClr;
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_strap_ctrl.sv
module cfg_strap_ctrl
  import cfg_strap_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 12'h0E0
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              clrBit,
  output cfgStrobe_t        strobe
);
  logic addrHit;

  always_comb begin
    addrHit       = (busAddr == CFG_OFFSET);
    strobe.wrHit  = busWrEn && addrHit;
    strobe.rdHit  = busRdEn && addrHit;
    strobe.errClr = busWrEn && addrHit && clrBit;
  end
endmodule

// File: rtl/cfg_strap_dp.sv
module cfg_strap_dp
  import cfg_strap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BOOT_W-1:0] strapBoot,
  input  logic              strapHost,
  input  logic              strapTmrDis,
  input  cfgStrobe_t        strobe,
  input  logic [RATE_W-1:0] wrRate,
  input  logic              wrRoute,
  input  logic              wrBusErr,
  input  logic              wdtEvent,
  output logic [DATA_W-1:0] busRdData,
  output logic [RATE_W-1:0] clkRateSel,
  output logic              nmiReq,
  output logic              rstReq,
  output logic              timerIntDis,
  output logic              errFlag
);
  logic [BOOT_W-1:0] bootSel;
  logic              hostMode;
  logic              tmrDis;
  logic [RATE_W-1:0] rateSel;
  logic              routeRst;
  logic              errSticky;
  logic [DATA_W-1:0] cfgWord;

  // straps load on every edge while reset is held, then freeze
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bootSel  <= strapBoot;
      hostMode <= strapHost;
      tmrDis   <= strapTmrDis;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateSel  <= '0;
      routeRst <= 1'b0;
    end else if (strobe.wrHit) begin
      rateSel  <= wrRate;
      routeRst <= wrRoute;
    end
  end

  // error set dominates a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rstN) errSticky <= 1'b0;
    else       errSticky <= wrBusErr || (errSticky && !strobe.errClr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiReq <= 1'b0;
      rstReq <= 1'b0;
    end else begin
      nmiReq <= wdtEvent && !routeRst;
      rstReq <= wdtEvent && routeRst;
    end
  end

  always_comb begin
    cfgWord = '0;
    cfgWord[RATE_LO +: RATE_W] = rateSel;
    cfgWord[BOOT_LO +: BOOT_W] = bootSel;
    cfgWord[HOST_BIT]          = hostMode;
    cfgWord[TDIS_BIT]          = tmrDis;
    cfgWord[BERR_BIT]          = errSticky;
    cfgWord[ROUTE_BIT]         = routeRst;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busRdData <= '0;
    else if (strobe.rdHit) busRdData <= cfgWord;
    else                   busRdData <= '0;
  end

  assign clkRateSel  = rateSel;
  assign timerIntDis = tmrDis;
  assign errFlag     = errSticky;
endmodule

// File: rtl/cfg_strap_reg.sv
module cfg_strap_reg
  import cfg_strap_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 12'h0E0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        strapBoot,
  input  logic              strapHost,
  input  logic              strapTmrDis,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              wrBusErr,
  input  logic              wdtEvent,
  output logic [1:0]        clkRateSel,
  output logic              nmiReq,
  output logic              rstReq,
  output logic              timerIntDis
);
  cfgStrobe_t strobe;
  logic       errFlag;

  cfg_strap_ctrl #(.ADDR_W(ADDR_W), .CFG_OFFSET(CFG_OFFSET)) u_ctrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .clrBit (busWrData[BERR_BIT]),
    .strobe (strobe)
  );

  cfg_strap_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strapBoot  (strapBoot),
    .strapHost  (strapHost),
    .strapTmrDis(strapTmrDis),
    .strobe     (strobe),
    .wrRate     (busWrData[RATE_LO +: RATE_W]),
    .wrRoute    (busWrData[ROUTE_BIT]),
    .wrBusErr   (wrBusErr),
    .wdtEvent   (wdtEvent),
    .busRdData  (busRdData),
    .clkRateSel (clkRateSel),
    .nmiReq     (nmiReq),
    .rstReq     (rstReq),
    .timerIntDis(timerIntDis),
    .errFlag    (errFlag)
  );
endmodule

// File: rtl/cfg_strap_chk.sv
module cfg_strap_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 12'h0E0
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic              wrBusErr,
  input logic              wdtEvent,
  input logic [1:0]        clkRateSel,
  input logic              nmiReq,
  input logic              rstReq,
  input logic              timerIntDis,
  input logic              errFlag
);
  // R1
  rate_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == CFG_OFFSET) |=> clkRateSel == $past(busWrData[25:24]));

  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrBusErr |=> errFlag);

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(busWrEn && busAddr == CFG_OFFSET && busWrData[16])) |=> errFlag);

  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(nmiReq && rstReq));

  // R8
  req_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wdtEvent |=> (!nmiReq && !rstReq));

  // R5
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(timerIntDis));

  // R9
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData[31:26] == 6'd0) && (busRdData[19:18] == 2'd0) && (busRdData[14:0] == 15'd0));

  // R10
  miss_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRdEn && busAddr == CFG_OFFSET) |=> busRdData == 32'd0);
endmodule

bind cfg_strap_reg cfg_strap_chk #(.ADDR_W(ADDR_W), .CFG_OFFSET(CFG_OFFSET)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busWrData  (busWrData),
  .busRdData  (busRdData),
  .wrBusErr   (wrBusErr),
  .wdtEvent   (wdtEvent),
  .clkRateSel (clkRateSel),
  .nmiReq     (nmiReq),
  .rstReq     (rstReq),
  .timerIntDis(timerIntDis),
  .errFlag    (errFlag)
);

// File: tb/cfg_strap_reg_bench.sv
module cfg_strap_reg_bench;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] OFS = 12'h0E0;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        strapBoot = '0;
  logic              strapHost = 1'b0;
  logic              strapTmrDis = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic              wrBusErr = 1'b0;
  logic              wdtEvent = 1'b0;
  logic [1:0]        clkRateSel;
  logic              nmiReq;
  logic              rstReq;
  logic              timerIntDis;

  int errors = 0;
  int checks = 0;

  // bench model
  logic [2:0] mBoot;
  logic       mHost, mTdis, mRoute, mErr;
  logic [1:0] mRate;
  logic [31:0] lastRd;

  always #4 clk = ~clk;

  cfg_strap_reg #(.ADDR_W(ADDR_W), .CFG_OFFSET(OFS)) u_cfg_strap_reg (
    .clk(clk), .rstN(rstN), .strapBoot(strapBoot), .strapHost(strapHost),
    .strapTmrDis(strapTmrDis), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .wrBusErr(wrBusErr), .wdtEvent(wdtEvent), .clkRateSel(clkRateSel),
    .nmiReq(nmiReq), .rstReq(rstReq), .timerIntDis(timerIntDis)
  );

  function automatic logic [31:0] expWord();
    logic [31:0] w = '0;
    w[25:24] = mRate; w[23:21] = mBoot; w[20] = mHost;
    w[17] = mTdis; w[16] = mErr; w[15] = mRoute;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit we, input bit rd, input logic [ADDR_W-1:0] addr,
                     input logic [31:0] wd, input bit err, input bit wdt);
    logic [31:0] eRd;
    bit eNmi, eRst, hit, both;
    @(negedge clk);
    busWrEn = we; busRdEn = rd; busAddr = addr; busWrData = wd;
    wrBusErr = err; wdtEvent = wdt;
    hit  = (addr == OFS);
    eRd  = (rd && hit) ? expWord() : 32'd0;
    eNmi = wdt && !mRoute;
    eRst = wdt && mRoute;
    both = err && we && hit && wd[16];
    if (we && hit) begin mRate = wd[25:24]; mRoute = wd[15]; end
    mErr = err || (mErr && !(we && hit && wd[16]));
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busRdEn = 1'b0; wrBusErr = 1'b0; wdtEvent = 1'b0;
    lastRd = busRdData;
    if (rd && hit) begin
      check(busRdData[25:24] == eRd[25:24], "R1", busRdData, eRd);
      check(busRdData[23:21] == eRd[23:21], "R2", busRdData, eRd);
      check(busRdData[20] == eRd[20], "R3", busRdData, eRd);
      check(busRdData[17] == eRd[17], "R4", busRdData, eRd);
      check(busRdData[16] == eRd[16], both ? "R7" : "R6", busRdData, eRd);
      check(busRdData[15] == eRd[15], "R8", busRdData, eRd);
      check(busRdData == eRd, "R9", busRdData, eRd);
    end else begin
      check(busRdData == 32'd0, "R10", busRdData, 32'd0);
    end
    check(clkRateSel == mRate, "R1", {30'd0, clkRateSel}, {30'd0, mRate});
    check(nmiReq == eNmi && rstReq == eRst, "R8", {30'd0, nmiReq, rstReq}, {30'd0, eNmi, eRst});
    check(timerIntDis == mTdis, "R4", {31'd0, timerIntDis}, {31'd0, mTdis});
  endtask

  task automatic doReset(input logic [2:0] b, input logic h, input logic t);
    @(negedge clk);
    rstN = 1'b0; strapBoot = b; strapHost = h; strapTmrDis = t;
    busWrEn = 1'b0; busRdEn = 1'b0; wrBusErr = 1'b0; wdtEvent = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mBoot = b; mHost = h; mTdis = t; mRate = 2'b00; mRoute = 1'b0; mErr = 1'b0;
    check(busRdData == 32'd0 && clkRateSel == 2'b00 && !nmiReq && !rstReq,
          "R1", {busRdData[31:3], clkRateSel, nmiReq | rstReq}, 32'd0);
    check(timerIntDis == t, "R4", {31'd0, timerIntDis}, {31'd0, t});
  endtask

  initial begin
    #(8 * 60000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mBoot = '0; mHost = 0; mTdis = 0; mRate = '0; mRoute = 0; mErr = 0; lastRd = '0;

    doReset(3'b011, 1'b1, 1'b0);
    cyc(0, 1, OFS, 0, 0, 0);
    // R5: move straps after release
    strapBoot = 3'b100; strapHost = 1'b0; strapTmrDis = 1'b1;
    cyc(0, 1, OFS, 0, 0, 0);
    check(lastRd[23:20] == 4'b0111 && timerIntDis == 1'b0, "R5", lastRd, 32'h0070_0000);
    // R9: all-ones write
    cyc(1, 0, OFS, 32'hFFFF_FFFF, 0, 0);
    cyc(0, 1, OFS, 0, 0, 0);
    // R8: route to reset, then NMI
    cyc(0, 0, OFS, 0, 0, 1);
    cyc(1, 0, OFS, 32'h0100_0000, 0, 1);
    cyc(0, 0, OFS, 0, 0, 1);
    // R6 / R7
    cyc(0, 0, OFS, 0, 1, 0);
    cyc(1, 1, OFS, 32'h0000_0000, 0, 0);
    cyc(1, 1, OFS, 32'h0001_0000, 1, 0);
    cyc(0, 1, OFS, 0, 0, 0);
    cyc(1, 0, OFS, 32'h0001_0000, 0, 0);
    cyc(0, 1, OFS, 0, 0, 0);
    // R10: other offsets
    cyc(1, 0, OFS ^ 12'h004, 32'h0301_8000, 1, 0);
    cyc(0, 1, OFS ^ 12'h800, 0, 0, 0);
    cyc(0, 1, OFS, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] a;
      a = ($urandom_range(0, 7) == 0) ? (OFS ^ ADDR_W'($urandom_range(1, 4095))) : OFS;
      cyc($urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1, a, $urandom(),
          $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0);
    end

    doReset(3'b101, 1'b0, 1'b1);
    strapBoot = 3'b010; strapHost = 1'b1; strapTmrDis = 1'b0;
    cyc(0, 1, OFS, 0, 0, 0);
    check(lastRd[23:20] == 4'b1010 && timerIntDis == 1'b1, "R5", lastRd, 32'h00A2_0000);
    cyc(0, 0, OFS, 0, 0, 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule